// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus. It has three registers: control/status at byte offset 0x0, the live count at 0x4 and the expiry limit at 0x8. When the watchdog is enabled, its counter goes up by one on each pulse of a slow tick input. If the count reaches the programmed limit, the block raises a one-cycle reset request and the counter stops.

Software keeps the timer alive, and gains the right to reconfigure it, only by writing magic words to the count register. A refresh key clears the count. An unlock key opens a fixed-length window of bus-clock cycles. During that window the control and limit registers accept writes, provided the update-permission bit is still set. A mode bit selects the key form: two 16-bit halves written one after the other, or one 32-bit word. In 16-bit mode, a refresh pair that is broken or out of order while the watchdog is enabled raises the reset request at once.

Top module: `skw_watchdog`

## Requirements
- R1: After reset the control register reads 0x0000_0020 (update permission set, everything else clear), the limit register reads RST_TOVAL, the count reads 0 and rst_req is low.
- R2: Control register field positions: bit 13 selects 32-bit keys, bit 11 reads 1 while unlocked, bit 10 reads 1 after an accepted control write, bit 7 enables counting, bit 5 permits updates. All other bits read 0.
- R3: In 16-bit mode, writing 0xA602 and then 0xB480 to the count register (low half of the data bus) clears the count to 0.
- R4: In 32-bit mode, the word 0xB480A602 clears the count. In this mode, 16-bit key halves cause neither a refresh nor a reset request.
- R5: An unlock key (0xC520 then 0xD928 in 16-bit mode, or 0xD928C520 in 32-bit mode) sets the unlocked bit. It also clears the reconfiguration-success bit.
- R6: Writes to the control or limit register while locked are ignored, and both registers keep their values.
- R7: The unlocked bit reads 1 for exactly UNLOCK_WIN cycles after the cycle of the unlock write, then clears.
- R8: While the update-permission bit is clear, writes to the control and limit registers are ignored even when the block is unlocked.
- R9: An accepted control write sets the reconfiguration-success bit, which reads 1 in the cycle after the write.
- R10: While enabled, each tick adds one to the count. On the tick where the count reaches the limit, rst_req is high for one cycle and the count then holds at the limit. While disabled, the count does not advance.
- R11: In 16-bit mode with counting enabled, a 0xB480 write without a preceding 0xA602, or a 0xA602 followed by any other word, raises rst_req in the next cycle. While disabled, such a write raises nothing.
- R12: An accepted write to the control or limit register clears the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable pulse from the slow time base |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Most internal faults show up at the ports within one or two cycles. A key checker stuck in a half-sequence state turns a valid refresh into a reset pulse, or swallows a refresh so that the count is not cleared on the next read. A faulty unlock timer is seen as the unlocked bit dropping one cycle early or late, relative to the UNLOCK_WIN boundary. A faulty comparison path is seen either as a reset pulse on the wrong tick or as a count that moves past the limit after expiry. Ignored locked writes are confirmed by reading the registers back right after the write.

// File: rtl/skw_pkg.sv
package skw_pkg;

    localparam int BUS_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_LIM  = 4'h8;

    localparam int B_CMD32 = 13;
    localparam int B_ULK   = 11;
    localparam int B_RCS   = 10;
    localparam int B_EN    = 7;
    localparam int B_UPD   = 5;

    localparam logic [15:0] K_REF_A = 16'hA602;
    localparam logic [15:0] K_REF_B = 16'hB480;
    localparam logic [15:0] K_ULK_A = 16'hC520;
    localparam logic [15:0] K_ULK_B = 16'hD928;
    localparam logic [31:0] K_REF_W = {K_REF_B, K_REF_A};
    localparam logic [31:0] K_ULK_W = {K_ULK_B, K_ULK_A};

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_REF_HALF,
        KS_ULK_HALF
    } key_state_e;

    typedef struct packed {
        logic cmd32;
        logic en;
        logic upd;
    } ctrl_cfg_t;

    typedef struct packed {
        logic refresh;
        logic unlock;
        logic violation;
    } key_evt_t;

    localparam ctrl_cfg_t CFG_RESET = '{cmd32: 1'b0, en: 1'b0, upd: 1'b1};

    function automatic logic [BUS_W-1:0] pack_ctrl(ctrl_cfg_t c, logic ulk, logic rcs);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_CMD32] = c.cmd32;
        w[B_ULK]   = ulk;
        w[B_RCS]   = rcs;
        w[B_EN]    = c.en;
        w[B_UPD]   = c.upd;
        return w;
    endfunction

endpackage

// File: rtl/skw_key_seq.sv
module skw_key_seq
    import skw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cnt,
    input  logic [BUS_W-1:0] wdata,
    input  logic             cmd32,
    output key_evt_t         evt
);

    key_state_e state_q, state_d;
    logic [15:0] lo;

    assign lo = wdata[15:0];

    always_comb begin
        state_d = state_q;
        evt     = '0;
        if (wr_cnt) begin
            if (cmd32) begin
                state_d     = KS_IDLE;
                evt.refresh = (wdata == K_REF_W);
                evt.unlock  = (wdata == K_ULK_W);
            end else begin
                unique case (state_q)
                    KS_IDLE: begin
                        if (lo == K_REF_A)      state_d = KS_REF_HALF;
                        else if (lo == K_ULK_A) state_d = KS_ULK_HALF;
                        else if (lo == K_REF_B) evt.violation = 1'b1;
                    end
                    KS_REF_HALF: begin
                        state_d = KS_IDLE;
                        if (lo == K_REF_B) evt.refresh   = 1'b1;
                        else               evt.violation = 1'b1;
                    end
                    KS_ULK_HALF: begin
                        state_d = KS_IDLE;
                        if (lo == K_ULK_B) evt.unlock = 1'b1;
                    end
                    default: state_d = KS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/skw_unlock_win.sv
module skw_unlock_win #(
    parameter int WIN = 255
) (
    input  logic clk,
    input  logic rst,
    input  logic open,
    output logic ulk
);

    localparam int TW = $clog2(WIN + 1);
    localparam logic [TW-1:0] WIN_LD = TW'(WIN);

    logic [TW-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (rst)                 timer_q <= '0;
        else if (open)           timer_q <= WIN_LD;
        else if (timer_q != '0)  timer_q <= timer_q - 1'b1;
    end

    assign ulk = (timer_q != '0);

endmodule

// File: rtl/skw_wd_counter.sv
module skw_wd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    logic             expired_q;
    logic [CNT_W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;
    assign hit = en && tick && !expired_q && !clear && (nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            expired_q <= 1'b0;
        end else if (clear) begin
            cnt       <= '0;
            expired_q <= 1'b0;
        end else if (en && tick && !expired_q) begin
            cnt <= nxt[CNT_W-1:0];
            if (hit) expired_q <= 1'b1;
        end
    end

endmodule

// File: rtl/skw_watchdog.sv
module skw_watchdog
    import skw_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int          UNLOCK_WIN = 255,
    parameter logic [31:0] RST_TOVAL  = 32'd60000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        rst_req
);

    localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(RST_TOVAL);

    ctrl_cfg_t        cfg_q;
    ctrl_cfg_t        cfg_d;
    logic             rcs_q;
    logic [CNT_W-1:0] toval_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ulk;
    logic             cfg_en, cfg_upd;
    key_evt_t         kev;
    logic             hit;
    logic             rst_req_q;
    logic             wr_ctrl, wr_cnt, wr_lim, may_cfg, ctrl_ok, lim_ok;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_cnt  = bus_sel && bus_wr && (bus_addr == OFS_CNT);
    assign wr_lim  = bus_sel && bus_wr && (bus_addr == OFS_LIM);
    assign may_cfg = ulk && cfg_q.upd;
    assign ctrl_ok = wr_ctrl && may_cfg;
    assign lim_ok  = wr_lim && may_cfg;
    assign cfg_en  = cfg_q.en;
    assign cfg_upd = cfg_q.upd;

    assign cfg_d = '{cmd32: bus_wdata[B_CMD32], en: bus_wdata[B_EN], upd: bus_wdata[B_UPD]};

    skw_key_seq u_keys (
        .clk    (clk),
        .rst    (rst),
        .wr_cnt (wr_cnt),
        .wdata  (bus_wdata),
        .cmd32  (cfg_q.cmd32),
        .evt    (kev)
    );

    skw_unlock_win #(.WIN(UNLOCK_WIN)) u_win (
        .clk  (clk),
        .rst  (rst),
        .open (kev.unlock),
        .ulk  (ulk)
    );

    skw_wd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg_q.en),
        .tick  (tick),
        .clear (kev.refresh || ctrl_ok || lim_ok),
        .limit (toval_q),
        .cnt   (cnt_q),
        .hit   (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            rcs_q     <= 1'b0;
            toval_q   <= LIM_RST;
            rst_req_q <= 1'b0;
        end else begin
            if (ctrl_ok) begin
                cfg_q <= cfg_d;
                rcs_q <= 1'b1;
            end else if (kev.unlock) begin
                rcs_q <= 1'b0;
            end
            if (lim_ok) toval_q <= bus_wdata[CNT_W-1:0];
            rst_req_q <= hit || (kev.violation && cfg_q.en);
        end
    end

    assign rst_req = rst_req_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL: bus_rdata = pack_ctrl(cfg_q, ulk, rcs_q);
            OFS_CNT:  bus_rdata = 32'(cnt_q);
            OFS_LIM:  bus_rdata = 32'(toval_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/skw_checker.sv
module skw_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic             ulk,
    input logic             en,
    input logic             upd,
    input logic             rcs,
    input logic [CNT_W-1:0] toval_q,
    input logic [CNT_W-1:0] cnt_q
);

    logic w_ctrl, w_lim;
    assign w_ctrl = bus_sel && bus_wr && (bus_addr == 4'h0);
    assign w_lim  = bus_sel && bus_wr && (bus_addr == 4'h8);

    AST_LOCKED_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (w_lim && !ulk) |=> $stable(toval_q)); // R6
    AST_LOCKED_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (w_ctrl && !ulk) |=> ($stable(en) && $stable(upd))); // R6
    AST_NOUPD_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (w_lim && !upd) |=> $stable(toval_q)); // R8
    AST_RCS_AFTER_CTRL: assert property (@(posedge clk) disable iff (rst)
        (w_ctrl && ulk && upd) |=> rcs); // R9
    AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (toval_q != '0) |-> (cnt_q <= toval_q)); // R10
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == $past(cnt_q) || cnt_q == '0)); // R10

endmodule

bind skw_watchdog skw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ulk      (ulk),
    .en       (cfg_en),
    .upd      (cfg_upd),
    .rcs      (rcs_q),
    .toval_q  (toval_q),
    .cnt_q    (cnt_q)
);

// File: tb/skw_watchdog_bench.sv
module skw_watchdog_bench;

    localparam int WIN = 255;
    localparam logic [31:0] TOV0 = 32'd60000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    skw_watchdog #(.CNT_W(32), .UNLOCK_WIN(WIN), .RST_TOVAL(TOV0)) u_skw_watchdog (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    function automatic logic [31:0] ctrl_word(bit c32, bit ul, bit rc, bit e, bit up);
        return (32'(c32) << 13) | (32'(ul) << 11) | (32'(rc) << 10) | (32'(e) << 7) | (32'(up) << 5);
    endfunction

    function automatic int next_count(int c, int lim);
        return (c >= lim) ? c : c + 1;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic unlock16();
        wr(4'h4, 32'h0000_C520);
        wr(4'h4, 32'h0000_D928);
    endtask

    task automatic refresh16();
        wr(4'h4, 32'h0000_A602);
        wr(4'h4, 32'h0000_B480);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h20);
        rd(4'h8, v); check("R1 limit", v, TOV0);
        rd(4'h4, v); check("R1 count", v, 0);
        check("R1 rst_req", 32'(rst_req), 0);

        // R6 locked writes; R11 disabled violation gives no pulse
        wr(4'h8, 32'd5);       rd(4'h8, v); check("R6 locked limit", v, TOV0);
        wr(4'h0, 32'hFFFF);    rd(4'h0, v); check("R6 locked ctrl", v, 32'h20);
        wr(4'h4, 32'h0000_B480); check("R11 disabled no pulse", 32'(rst_req), 0);

        // R5 unlock 16-bit, R2 bit positions
        unlock16();
        rd(4'h0, v); check("R5 R2 unlocked", v, ctrl_word(0, 1, 0, 0, 1));
        wr(4'h8, 32'd10);      rd(4'h8, v); check("R6 unlocked limit write", v, 32'd10);
        wr(4'h0, 32'h0000_00A0);
        rd(4'h0, v); check("R9 R2 rcs after ctrl", v, ctrl_word(0, 1, 1, 1, 1));

        // R10 counting, R3 refresh
        repeat (3) pulse_tick();
        rd(4'h4, v); check("R10 count 3", v, 3);
        refresh16();
        rd(4'h4, v); check("R3 refresh clears", v, 0);
        check("R3 no pulse", 32'(rst_req), 0);

        // R11 violations while enabled
        wr(4'h4, 32'h0000_B480); check("R11 lone second half", 32'(rst_req), 1);
        @(negedge clk);        check("R11 pulse one cycle", 32'(rst_req), 0);
        wr(4'h4, 32'h0000_A602);
        wr(4'h4, 32'h0000_1234); check("R11 broken pair", 32'(rst_req), 1);

        // R7 window length
        unlock16();
        repeat (WIN - 1) @(negedge clk);
        rd(4'h0, v); check("R7 last unlocked cycle", 32'(v[11]), 1);
        @(negedge clk);
        rd(4'h0, v); check("R7 relocked", 32'(v[11]), 0);
        wr(4'h8, 32'd77);      rd(4'h8, v); check("R6 relocked limit", v, 32'd10);

        // R10 expiry, R12 clear on limit write
        pulse_tick();
        unlock16();
        wr(4'h8, 32'd4);       rd(4'h4, v); check("R12 limit write clears", v, 0);
        for (int i = 0; i < 3; i++) begin
            pulse_tick(); check("R10 before limit", 32'(rst_req), 0);
        end
        pulse_tick(); check("R10 expiry pulse", 32'(rst_req), 1);
        rd(4'h4, v); check("R10 count at limit", v, 4);
        @(negedge clk); check("R10 pulse ends", 32'(rst_req), 0);
        pulse_tick(); pulse_tick();
        rd(4'h4, v); check("R10 count holds", v, 4);
        check("R10 no repeat pulse", 32'(rst_req), 0);

        // R4 32-bit mode
        wr(4'h0, 32'h0000_20A0);
        rd(4'h4, v); check("R12 ctrl write clears", v, 0);
        pulse_tick(); pulse_tick();
        wr(4'h4, 32'h0000_A602); check("R4 half ignored", 32'(rst_req), 0);
        wr(4'h4, 32'h0000_B480); check("R4 half no violation", 32'(rst_req), 0);
        rd(4'h4, v); check("R4 halves no refresh", v, 2);
        wr(4'h4, 32'hB480_A602);
        rd(4'h4, v); check("R4 word refresh", v, 0);
        wr(4'h4, 32'hD928_C520);
        rd(4'h0, v); check("R5 R9 unlock32 clears rcs", v, ctrl_word(1, 1, 0, 1, 1));

        // R8 update permission dropped
        wr(4'h0, 32'h0000_2080);
        rd(4'h0, v); check("R8 upd cleared", v, ctrl_word(1, 1, 1, 1, 0));
        wr(4'h8, 32'd99);      rd(4'h8, v); check("R8 limit frozen", v, 32'd4);
        wr(4'h0, 32'h0000_20A0); rd(4'h0, v); check("R8 ctrl frozen", 32'(v[5]), 0);

        // randomized rounds in 16-bit mode
        do_reset();
        begin
            int lim;
            lim = $urandom_range(2, 12);
            unlock16();
            wr(4'h8, 32'(lim));
            wr(4'h0, 32'h0000_00A0);
            for (int r = 0; r < 8; r++) begin
                int c, n;
                bit fire;
                c = 0;
                n = $urandom_range(0, lim + 2);
                for (int k = 0; k < n; k++) begin
                    fire = (c < lim) && (c + 1 >= lim);
                    c = next_count(c, lim);
                    pulse_tick();
                    check("R10 random pulse", 32'(rst_req), 32'(fire));
                end
                rd(4'h4, v); check("R10 random count", v, 32'(c));
                refresh16();
                rd(4'h4, v); check("R3 random refresh", v, 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule